// File: doc/BRIEF.md
# Resending Frame Transmit Buffer

This block stores one outgoing radio frame of up to 128 bytes and streams it to a byte-wide modulator. The host loads the frame one byte at a time, length byte first, and then issues a start command. After a fixed wait counted in symbol periods, the block emits a sync header of zero bytes and a start-of-frame delimiter. It then sends the stored length byte and that many payload bytes over a valid/ready handshake.

The frame is kept after it has been sent. A further start command sends it again without reloading. The first host write after a finished send empties the buffer before storing that byte, so a new frame can be loaded without an explicit flush. If the stream reaches a byte that the host has not yet written, the send stops and a sticky underflow flag is set. While that flag is set the buffer refuses writes, and only the flush command clears it. A debug read port returns any stored byte and leaves the buffer contents unchanged.

Top module: `txbuf_resend`

## Requirements
- R1: After reset, busy_o, mod_valid_o, underflow_o and status_o are 0, and the delimiter register holds 0xA7.
- R2: cmd_tx_i starts a send whatever the value of chan_clear_i. cmd_tx_cca_i starts a send only when chan_clear_i is 1 in the same cycle; otherwise it has no effect and busy_o stays 0.
- R3: After an accepted start, the output stays silent until 12 symbol_tick_i pulses have been counted. It then sends 4 bytes of 0x00 and one delimiter byte. The delimiter is the value last written through sfd_we_i/sfd_data_i.
- R4: After the delimiter, the block sends buffer byte 0 (the length L) and then bytes 1..L in order, each transfer completing when mod_valid_o and mod_ready_i are both 1. busy_o is 1 from the cycle after the accepted start until the last byte has been accepted.
- R5: When the next frame byte has not been written, the send stops: busy_o falls and underflow_o becomes 1. underflow_o then stays 1, and host writes are ignored while it is set.
- R6: cmd_flush_i empties the buffer, clears underflow_o and aborts any send in progress, so busy_o is 0 on the next cycle.
- R7: After a complete send, a new start command sends the identical frame again.
- R8: The first host write after a complete send discards the old frame and stores the written byte at address 0.
- R9: The buffer holds at most 128 bytes. Writes beyond that are dropped, and a frame with L=127 is sent in full.
- R10: dbg_data_o shows the stored byte at dbg_addr_i combinationally, and reading it changes nothing.
- R11: On each host write, status_o captures the value underflow_o had before that write, and holds it until the next write.
- R12: Start commands that arrive while busy_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_data_i | input | 8 | Host write byte |
| status_o | output | 1 | Underflow state captured at the last host write |
| cmd_tx_i | input | 1 | Start command, unconditional |
| cmd_tx_cca_i | input | 1 | Start command, only if the channel is clear |
| cmd_flush_i | input | 1 | Flush command |
| chan_clear_i | input | 1 | Channel assessment result, 1 = clear |
| symbol_tick_i | input | 1 | One-cycle pulse per symbol period |
| sfd_we_i | input | 1 | Delimiter register write |
| sfd_data_i | input | 8 | Delimiter register value |
| mod_ready_i | input | 1 | Modulator accepts a byte |
| mod_valid_o | output | 1 | Byte offered to the modulator |
| mod_data_o | output | 8 | Byte to the modulator |
| busy_o | output | 1 | Send in progress |
| underflow_o | output | 1 | Sticky underflow flag |
| dbg_addr_i | input | 7 | Debug read address |
| dbg_data_o | output | 8 | Debug read data |

## Verification
The hardest state to reach from the ports is the one right after an underflow. Here a stale partial frame is still stored, writes are refused, and a resend must fail at the same byte again. The bench loads a length of 5 with only two payload bytes and sends it. It then writes one more byte, which must be refused with status_o reading 1, and sends again. That second send must produce exactly the same eight bytes, which proves the write was dropped. The same bench also sends a frame after a full 129-byte load, so the last address is filled and the write that overflows the buffer is dropped.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_SFD,
    ST_DATA
  } txbuf_state_e;
endpackage

// File: rtl/txbuf_store.sv
module txbuf_store #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] tx_addr_i,
  output logic [7:0]    tx_data_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [7:0]    dbg_data_o,
  output logic [7:0]    len_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign tx_data_o  = mem_q[tx_addr_i];
  assign dbg_data_o = mem_q[dbg_addr_i];
  assign len_o      = mem_q[0];
endmodule

// File: rtl/txbuf_fill.sv
module txbuf_fill #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          flush_i,
  input  logic          tx_start_i,
  input  logic          tx_done_i,
  input  logic          uf_set_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [CW-1:0] count_o,
  output logic          uf_o,
  output logic          status_o
);
  logic [CW-1:0] count_q;
  logic          sent_q, uf_q, status_q;
  logic          accept;

  // after a completed send the buffer refills from address 0
  assign accept      = wr_en_i && !flush_i && !uf_q && (sent_q || (count_q < CW'(DEPTH)));
  assign mem_we_o    = accept;
  assign mem_waddr_o = sent_q ? '0 : count_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      sent_q   <= 1'b0;
      uf_q     <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (wr_en_i) status_q <= uf_q;
      if (flush_i) begin
        count_q <= '0;
        sent_q  <= 1'b0;
        uf_q    <= 1'b0;
      end else begin
        if (accept) count_q <= sent_q ? CW'(1) : count_q + CW'(1);
        if (tx_done_i)       sent_q <= 1'b1;
        else if (tx_start_i) sent_q <= 1'b0;
        else if (accept)     sent_q <= 1'b0;
        if (uf_set_i) uf_q <= 1'b1;
      end
    end
  end

  assign count_o  = count_q;
  assign uf_o     = uf_q;
  assign status_o = status_q;

  a_r9_count_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r5_uf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q && !flush_i |=> uf_q);
  a_r5_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q |-> !mem_we_o);
endmodule

// File: rtl/txbuf_seq.sv
module txbuf_seq
  import txbuf_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int AW      = $clog2(DEPTH),
  parameter int CW      = $clog2(DEPTH + 1),
  parameter int DELAY   = 12,
  parameter int PRE_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_tx_i,
  input  logic          cmd_tx_cca_i,
  input  logic          chan_clear_i,
  input  logic          flush_i,
  input  logic          symbol_tick_i,
  input  logic          mod_ready_i,
  input  logic [CW-1:0] count_i,
  input  logic [7:0]    len_i,
  input  logic [7:0]    rdata_i,
  input  logic [7:0]    sfd_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          mod_valid_o,
  output logic [7:0]    mod_data_o,
  output logic          busy_o,
  output logic          start_o,
  output logic          done_o,
  output logic          uf_set_o
);
  localparam int SW = $clog2(DELAY + 1);
  localparam int PW = $clog2(PRE_LEN + 1);

  txbuf_state_e  state_q;
  logic [SW-1:0] sym_q;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] rd_q;
  logic          have, last;

  assign start_o   = (state_q == ST_IDLE) && !flush_i &&
                     (cmd_tx_i || (cmd_tx_cca_i && chan_clear_i));
  assign have      = rd_q < count_i;
  assign last      = rd_q == CW'(len_i);
  assign rd_addr_o = rd_q[AW-1:0];
  assign busy_o    = state_q != ST_IDLE;

  always_comb begin
    mod_valid_o = 1'b0;
    mod_data_o  = 8'h00;
    uf_set_o    = 1'b0;
    done_o      = 1'b0;
    case (state_q)
      ST_PRE:  mod_valid_o = 1'b1;
      ST_SFD: begin
        mod_valid_o = 1'b1;
        mod_data_o  = sfd_i;
      end
      ST_DATA: begin
        mod_valid_o = have;
        mod_data_o  = have ? rdata_i : 8'h00;
        uf_set_o    = !have && !flush_i;
        done_o      = have && mod_ready_i && last && !flush_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sym_q   <= '0;
      pre_q   <= '0;
      rd_q    <= '0;
    end else if (flush_i) begin
      state_q <= ST_IDLE;
      sym_q   <= '0;
      pre_q   <= '0;
      rd_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_o) begin
          state_q <= ST_WAIT;
          sym_q   <= '0;
        end
        ST_WAIT: if (symbol_tick_i) begin
          if (sym_q == SW'(DELAY - 1)) begin
            state_q <= ST_PRE;
            pre_q   <= '0;
          end else begin
            sym_q <= sym_q + SW'(1);
          end
        end
        ST_PRE: if (mod_ready_i) begin
          if (pre_q == PW'(PRE_LEN - 1)) state_q <= ST_SFD;
          else pre_q <= pre_q + PW'(1);
        end
        ST_SFD: if (mod_ready_i) begin
          state_q <= ST_DATA;
          rd_q    <= '0;
        end
        ST_DATA: begin
          if (!have) state_q <= ST_IDLE;
          else if (mod_ready_i) begin
            if (last) state_q <= ST_IDLE;
            else rd_q <= rd_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_tick_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) && !symbol_tick_i && !flush_i |=> state_q == ST_WAIT);
  a_r12_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_PRE, ST_SFD, ST_DATA}) |=> state_q != ST_WAIT);
endmodule

// File: rtl/txbuf_resend.sv
module txbuf_resend #(
  parameter int         DEPTH   = 128,
  parameter int         DELAY   = 12,
  parameter int         PRE_LEN = 4,
  parameter logic [7:0] SFD_RST = 8'hA7,
  localparam int        AW      = $clog2(DEPTH),
  localparam int        CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  output logic          status_o,
  input  logic          cmd_tx_i,
  input  logic          cmd_tx_cca_i,
  input  logic          cmd_flush_i,
  input  logic          chan_clear_i,
  input  logic          symbol_tick_i,
  input  logic          sfd_we_i,
  input  logic [7:0]    sfd_data_i,
  input  logic          mod_ready_i,
  output logic          mod_valid_o,
  output logic [7:0]    mod_data_o,
  output logic          busy_o,
  output logic          underflow_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [7:0]    dbg_data_o
);
  logic [7:0]    sfd_q;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, rd_addr;
  logic [7:0]    rdata, len;
  logic [CW-1:0] count;
  logic          start, done, uf_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sfd_q <= SFD_RST;
    else if (sfd_we_i) sfd_q <= sfd_data_i;
  end

  txbuf_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk_i      (clk_i),
    .we_i       (mem_we),
    .waddr_i    (mem_waddr),
    .wdata_i    (wr_data_i),
    .tx_addr_i  (rd_addr),
    .tx_data_o  (rdata),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o),
    .len_o      (len)
  );

  txbuf_fill #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .flush_i     (cmd_flush_i),
    .tx_start_i  (start),
    .tx_done_i   (done),
    .uf_set_i    (uf_set),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .count_o     (count),
    .uf_o        (underflow_o),
    .status_o    (status_o)
  );

  txbuf_seq #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .DELAY(DELAY), .PRE_LEN(PRE_LEN)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_tx_i      (cmd_tx_i),
    .cmd_tx_cca_i  (cmd_tx_cca_i),
    .chan_clear_i  (chan_clear_i),
    .flush_i       (cmd_flush_i),
    .symbol_tick_i (symbol_tick_i),
    .mod_ready_i   (mod_ready_i),
    .count_i       (count),
    .len_i         (len),
    .rdata_i       (rdata),
    .sfd_i         (sfd_q),
    .rd_addr_o     (rd_addr),
    .mod_valid_o   (mod_valid_o),
    .mod_data_o    (mod_data_o),
    .busy_o        (busy_o),
    .start_o       (start),
    .done_o        (done),
    .uf_set_o      (uf_set)
  );

  a_r4_valid_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_valid_o |-> busy_o);
  a_r6_flush_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_flush_i |=> !busy_o);
endmodule

// File: tb/test_txbuf_resend.sv
module test_txbuf_resend;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, cmd_tx_i = 1'b0, cmd_tx_cca_i = 1'b0, cmd_flush_i = 1'b0;
  logic [7:0] wr_data_i = '0, sfd_data_i = '0;
  logic       chan_clear_i = 1'b1, symbol_tick_i = 1'b0, sfd_we_i = 1'b0, mod_ready_i = 1'b1;
  logic [6:0] dbg_addr_i = '0;
  logic       status_o, mod_valid_o, busy_o, underflow_o;
  logic [7:0] mod_data_o, dbg_data_o;

  txbuf_resend i_txbuf_resend (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic [7:0] frm [256];
  logic [7:0] got [256];
  logic [7:0] expv [256];
  int n_got, n_exp, first_ticks;

  // {len, seed, use_cca, chan_clear, stall, expect_start, 4'b0}
  localparam logic [23:0] VEC [6] = '{
    {8'd3,  8'h10, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0},
    {8'd0,  8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0},
    {8'd20, 8'h30, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0},
    {8'd5,  8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0},
    {8'd9,  8'h50, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0},
    {8'd60, 8'h80, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = b;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk_i);
    cmd_tx_i = (which == 0); cmd_tx_cca_i = (which == 1); cmd_flush_i = (which == 2);
    @(negedge clk_i);
    cmd_tx_i = 1'b0; cmd_tx_cca_i = 1'b0; cmd_flush_i = 1'b0;
  endtask

  task automatic load(input logic [7:0] len, input logic [7:0] seed, input int n);
    frm[0] = len;
    wr_byte(len);
    for (int i = 1; i < n; i++) begin
      frm[i] = seed + 8'(i - 1);
      wr_byte(frm[i]);
    end
  endtask

  // inj_kind: 0 start strobe, 2 flush
  task automatic run_tx(input int max, input bit stall, input int inj_at, input int inj_kind);
    int tick_cnt = 0;
    n_got = 0; first_ticks = -1;
    for (int c = 0; c < max; c++) begin
      if (c > 0) @(negedge clk_i);
      mod_ready_i   = stall ? c[0] : 1'b1;
      symbol_tick_i = (c % 4 == 3);
      cmd_tx_i      = (c == inj_at) && (inj_kind == 0);
      cmd_flush_i   = (c == inj_at) && (inj_kind == 2);
      #1;
      if (mod_valid_o && mod_ready_i) begin
        if (n_got == 0) first_ticks = tick_cnt;
        got[n_got] = mod_data_o;
        n_got++;
      end
      if (symbol_tick_i) tick_cnt++;
      if (!busy_o && c != inj_at) break;
    end
    @(negedge clk_i);
    mod_ready_i = 1'b1; symbol_tick_i = 1'b0; cmd_tx_i = 1'b0; cmd_flush_i = 1'b0;
  endtask

  task automatic build_exp(input int nb, input logic [7:0] sfd);
    for (int i = 0; i < 4; i++) expv[i] = 8'h00;
    expv[4] = sfd;
    for (int i = 0; i < nb; i++) expv[5 + i] = frm[i];
    n_exp = 5 + nb;
  endtask

  task automatic cmp_stream(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < n_exp && i < n_got; i++)
      if (got[i] !== expv[i]) begin bad++; if (first < 0) first = i; end
    chk(n_got == n_exp, {req, " stream length"}, n_got, n_exp);
    chk(bad == 0, {req, " stream bytes"}, first < 0 ? 0 : int'(got[first]),
        first < 0 ? 0 : int'(expv[first]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(mod_valid_o == 0, "R1 valid", mod_valid_o, 0);
    chk(underflow_o == 0, "R1 underflow", underflow_o, 0);
    chk(status_o == 0, "R1 status", status_o, 0);

    // table: R1 delimiter reset, R2 strobe types, R3 delay/header, R4 body
    for (int k = 0; k < 6; k++) begin
      logic [7:0] len, seed;
      logic use_cca, clr, stall, go;
      {len, seed, use_cca, clr, stall, go} = VEC[k][23:4];
      pulse(2);
      load(len, seed, int'(len) + 1);
      chan_clear_i = clr;
      pulse(use_cca ? 1 : 0);
      chan_clear_i = 1'b1;
      run_tx(4000, stall, -1, 0);
      if (go) begin
        build_exp(int'(len) + 1, 8'hA7);
        cmp_stream("R4 R1");
        chk(first_ticks == 12, "R3 start delay", first_ticks, 12);
        chk(busy_o == 0, "R4 busy end", busy_o, 0);
      end else begin
        chk(n_got == 0 && busy_o == 0, "R2 cca busy ignored", n_got, 0);
      end
    end

    // R7 resend of last frame (len 60 from table)
    pulse(0);
    run_tx(4000, 1'b0, -1, 0);
    build_exp(61, 8'hA7);
    cmp_stream("R7");

    // R12 start strobe during a send is ignored
    pulse(0);
    run_tx(4000, 1'b0, 20, 0);
    cmp_stream("R12");
    chk(first_ticks == 12, "R12 delay kept", first_ticks, 12);
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0, "R12 no restart", busy_o, 0);

    // R8 auto flush on first write after send
    load(8'd2, 8'hC1, 3);
    dbg_addr_i = 7'd0; #1;
    chk(dbg_data_o == 8'd2, "R8 R10 dbg addr0", dbg_data_o, 2);
    dbg_addr_i = 7'd2; #1;
    chk(dbg_data_o == 8'hC2, "R10 dbg addr2", dbg_data_o, 8'hC2);
    pulse(0);
    run_tx(4000, 1'b0, -1, 0);
    build_exp(3, 8'hA7);
    cmp_stream("R8");

    // R10 debug reads left contents intact; R3 programmed delimiter
    dbg_addr_i = 7'd1; #1;
    chk(dbg_data_o == 8'hC1, "R10 dbg after send", dbg_data_o, 8'hC1);
    @(negedge clk_i); sfd_we_i = 1'b1; sfd_data_i = 8'h5A;
    @(negedge clk_i); sfd_we_i = 1'b0;
    pulse(0);
    run_tx(4000, 1'b0, -1, 0);
    build_exp(3, 8'h5A);
    cmp_stream("R3 R10");

    // R5 underflow: length 5, only 2 payload bytes
    pulse(2);
    load(8'd5, 8'h01, 3);
    pulse(0);
    run_tx(4000, 1'b0, -1, 0);
    build_exp(3, 8'h5A);
    cmp_stream("R5");
    chk(underflow_o == 1, "R5 flag set", underflow_o, 1);
    wr_byte(8'h03);
    chk(status_o == 1, "R11 status on write", status_o, 1);
    pulse(0);
    run_tx(4000, 1'b0, -1, 0);
    cmp_stream("R5 write ignored");
    chk(underflow_o == 1, "R5 flag sticky", underflow_o, 1);

    // R6 flush clears flag; R11 status tracks it
    pulse(2);
    chk(underflow_o == 0, "R6 flush clears", underflow_o, 1'b0);
    load(8'd0, 8'h00, 1);
    chk(status_o == 0, "R11 status clear", status_o, 0);
    pulse(0);
    run_tx(4000, 1'b0, -1, 0);
    build_exp(1, 8'h5A);
    cmp_stream("R6 after flush");

    // R6 flush aborts a send in its wait phase
    pulse(0);
    run_tx(4000, 1'b0, 30, 2);
    chk(n_got == 0 && busy_o == 0, "R6 abort", n_got, 0);

    // R9 capacity: length 127 plus 128 data writes, last dropped
    load(8'd127, 8'h90, 129);
    dbg_addr_i = 7'd127; #1;
    chk(dbg_data_o == frm[127], "R9 last addr", dbg_data_o, frm[127]);
    pulse(0);
    run_tx(4000, 1'b0, -1, 0);
    build_exp(128, 8'h5A);
    cmp_stream("R9");
    chk(underflow_o == 0, "R9 full frame no underflow", underflow_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule